// File: doc/BRIEF.md
# SPI Register-Bank Access Engine

This block sits behind an SPI slave front-end that has already turned the serial line into whole bytes. It turns that byte stream into register accesses. Within each frame (the span in which the slave select is active) the first byte received programs a control register and the second programs an address pointer. Every byte after those two is a data byte. It either writes one of a bank of read/write configuration registers or reads from that bank or from a bank of read-only status registers. The bank, the direction and the pointer stepping are all fixed by the control byte.

The configuration bank is exported as one flat vector. The status bank is sampled from one flat input vector. For reads, the engine preloads the transmit byte so that the front-end can shift it out from the first edge of the next byte. Each register event is reported on its own one-cycle strobe, and these strobes can serve as interrupts or data-valid flags for neighbouring logic. Serial bit timing, clock polarity and phase, and output tri-stating belong to the front-end.

Top module: `spi_rbank_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the control register, the address register, every configuration register and the transmit byte are 0, and all five event strobes are low.
- R2: Within a frame, the first received byte is stored in the control register and `ev_ctl_wr` pulses. The second received byte is stored in the address register and `ev_adr_wr` pulses. Each is visible in the cycle after the byte's `rx_vld` cycle.
- R3: Control bit 0 is the direction (0 = write, 1 = read). Control bit 1 is the bank (0 = configuration, 1 = status). Control bit 2 is the step mode (0 = auto-increment, 1 = hold). Control bits 7:3 appear unchanged on `usr_flags[4:0]`.
- R4: A data byte in a configuration write frame stores into configuration register k = pointer mod NCFG, which drives bits 8k+7:8k of `cfg_flat`, and pulses `ev_cfg_wr`.
- R5: With auto-increment, each data byte moves the pointer to (pointer+1) mod N of the selected bank, so it wraps to 0 after the highest register.
- R6: With step mode set to hold, the pointer keeps its value across data bytes.
- R7: A data byte in a status write frame changes no configuration register and raises no strobe. The pointer still steps.
- R8: In read frames, `tx_data` is loaded from the selected bank at the new address when the address byte completes, and at the stepped pointer after each data byte. Each read data byte pulses `ev_cfg_rd` or `ev_sts_rd` according to the bank.
- R9: Bytes that arrive while `frame_act` is low are ignored. When a frame ends, the next frame starts again with a control byte.
- R10: Only the low log2(N) bits of the pointer select a register, so an address at or above N aliases to address mod N.
- R11: Every strobe lasts one cycle per byte, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_act | input | 1 | High while the slave is selected (synchronised by the front-end) |
| rx_vld | input | 1 | One-cycle pulse: a complete byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_data | output | 8 | Byte to shift out on the next read byte |
| sts_flat | input | NSTS*8 | Status bank; register n on bits 8n+7:8n |
| cfg_flat | output | NCFG*8 | Configuration bank; register n on bits 8n+7:8n |
| ctl_reg | output | 8 | Current control register |
| adr_reg | output | 8 | Current address pointer |
| usr_flags | output | 5 | Control bits 7:3 |
| ev_ctl_wr | output | 1 | Control register written |
| ev_adr_wr | output | 1 | Address register written |
| ev_cfg_wr | output | 1 | Configuration register written |
| ev_cfg_rd | output | 1 | Configuration register read |
| ev_sts_rd | output | 1 | Status register read |

## Verification
The hardest case to reach is the pointer wrap combined with aliasing. For that, a frame must carry a start address near or beyond the top of the bank and then keep streaming data bytes without ending the frame. The stimulus writes three bytes from address 2 of a four-entry bank and reads from address 6, and the expected register image comes from a bench model that steps its pointer modulo the bank size. A second difficult case is a byte that arrives outside a frame. It is driven with `frame_act` low, and the bench then checks that the next frame still begins with a control byte.

// File: rtl/spi_rbank_pkg.sv
package spi_rbank_pkg;

  typedef enum logic [1:0] {
    PH_CTL = 2'd0,
    PH_ADR = 2'd1,
    PH_DAT = 2'd2
  } phase_t;

  localparam int CB_DIR  = 0;
  localparam int CB_BANK = 1;
  localparam int CB_HOLD = 2;

  // Pointer mask for a bank with n registers (n a power of two, 2..256).
  function automatic logic [7:0] bank_mask(input int unsigned n);
    return 8'(n - 1);
  endfunction

  // Pointer after one data byte.
  function automatic logic [7:0] ptr_next(input logic [7:0] cur,
                                          input logic       hold,
                                          input logic [7:0] mask);
    return hold ? cur : ((cur + 8'd1) & mask);
  endfunction

endpackage

// File: rtl/spi_rbank_ctrl.sv
module spi_rbank_ctrl
  import spi_rbank_pkg::*;
#(
  parameter int NCFG = 4,
  parameter int NSTS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_act,
  input  logic       rx_vld,
  input  logic [7:0] rx_data,
  output logic [7:0] ctl_q,
  output logic [7:0] adr_q,
  output logic       cfg_we,
  output logic [7:0] cfg_wadr,
  output logic       fetch_en,
  output logic       fetch_bank,
  output logic [7:0] fetch_adr,
  output logic       ev_ctl_wr,
  output logic       ev_adr_wr,
  output logic       ev_cfg_wr,
  output logic       ev_cfg_rd,
  output logic       ev_sts_rd
);

  localparam logic [7:0] CFG_MASK = bank_mask(NCFG);
  localparam logic [7:0] STS_MASK = bank_mask(NSTS);

  phase_t     phase_q;
  logic       hit_ctl, hit_adr, hit_dat;
  logic       is_rd, is_sts, is_hold;
  logic [7:0] cur_mask, adr_step;

  assign hit_ctl = frame_act && rx_vld && (phase_q == PH_CTL);
  assign hit_adr = frame_act && rx_vld && (phase_q == PH_ADR);
  assign hit_dat = frame_act && rx_vld && (phase_q == PH_DAT);

  assign is_rd    = ctl_q[CB_DIR];
  assign is_sts   = ctl_q[CB_BANK];
  assign is_hold  = ctl_q[CB_HOLD];
  assign cur_mask = is_sts ? STS_MASK : CFG_MASK;
  assign adr_step = ptr_next(adr_q, is_hold, cur_mask);

  assign cfg_we     = hit_dat && !is_rd && !is_sts;
  assign cfg_wadr   = adr_q;
  assign fetch_en   = hit_adr || hit_dat;
  assign fetch_bank = is_sts;
  assign fetch_adr  = hit_adr ? rx_data : adr_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CTL;
      ctl_q   <= 8'h00;
      adr_q   <= 8'h00;
    end else if (!frame_act) begin
      phase_q <= PH_CTL;
    end else if (hit_ctl) begin
      ctl_q   <= rx_data;
      phase_q <= PH_ADR;
    end else if (hit_adr) begin
      adr_q   <= rx_data;
      phase_q <= PH_DAT;
    end else if (hit_dat) begin
      adr_q   <= adr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_ctl_wr <= 1'b0;
      ev_adr_wr <= 1'b0;
      ev_cfg_wr <= 1'b0;
      ev_cfg_rd <= 1'b0;
      ev_sts_rd <= 1'b0;
    end else begin
      ev_ctl_wr <= hit_ctl;
      ev_adr_wr <= hit_adr;
      ev_cfg_wr <= cfg_we;
      ev_cfg_rd <= hit_dat && is_rd && !is_sts;
      ev_sts_rd <= hit_dat && is_rd && is_sts;
    end
  end

  // R2: control captured from the byte that raised the strobe
  a_r2_ctl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> (ev_ctl_wr && ctl_q == $past(rx_data)));

  // R2: address captured from the byte that raised the strobe
  a_r2_adr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit_adr |=> (ev_adr_wr && adr_q == $past(rx_data)));

  // R6: hold mode keeps the pointer across a data byte
  a_r6_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat && is_hold) |=> $stable(adr_q));

  // R5: after an incrementing step the pointer lies inside the bank
  a_r5_ptr_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat && !is_hold) |=> ((adr_q & ~$past(cur_mask)) == 8'h00));

  // R9: bytes outside a frame change neither header register
  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_act) |=> ($stable(ctl_q) && $stable(adr_q)));

endmodule

// File: rtl/spi_rbank_cfg.sv
module spi_rbank_cfg #(
  parameter int NCFG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        wadr,
  input  logic [7:0]        wdata,
  output logic [NCFG*8-1:0] flat
);

  localparam int AW = $clog2(NCFG);

  logic [AW-1:0] widx;
  assign widx = wadr[AW-1:0];

  for (genvar gi = 0; gi < NCFG; gi++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= 8'h00;
      else if (we && (widx == AW'(gi)))
        val_q <= wdata;
    end
    assign flat[gi*8 +: 8] = val_q;
  end

  // R4/R7: the bank moves only on a write enable
  a_r7_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));

endmodule

// File: rtl/spi_rbank_rd.sv
module spi_rbank_rd #(
  parameter int NCFG = 4,
  parameter int NSTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              fetch_bank,
  input  logic [7:0]        fetch_adr,
  input  logic [NCFG*8-1:0] cfg_flat,
  input  logic [NSTS*8-1:0] sts_flat,
  output logic [7:0]        tx_q
);

  localparam int CAW = $clog2(NCFG);
  localparam int SAW = $clog2(NSTS);

  logic [CAW-1:0] cidx;
  logic [SAW-1:0] sidx;
  logic [7:0]     cfg_byte, sts_byte, pick;

  assign cidx     = fetch_adr[CAW-1:0];
  assign sidx     = fetch_adr[SAW-1:0];
  assign cfg_byte = cfg_flat[int'(cidx)*8 +: 8];
  assign sts_byte = sts_flat[int'(sidx)*8 +: 8];
  assign pick     = fetch_bank ? sts_byte : cfg_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_q <= 8'h00;
    else if (fetch_en)
      tx_q <= pick;
  end

  // R8: transmit byte changes only on a fetch
  a_r8_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(tx_q));

endmodule

// File: rtl/spi_rbank_top.sv
module spi_rbank_top
  import spi_rbank_pkg::*;
#(
  parameter int NCFG = 4,
  parameter int NSTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  output logic [7:0]        tx_data,
  input  logic [NSTS*8-1:0] sts_flat,
  output logic [NCFG*8-1:0] cfg_flat,
  output logic [7:0]        ctl_reg,
  output logic [7:0]        adr_reg,
  output logic [4:0]        usr_flags,
  output logic              ev_ctl_wr,
  output logic              ev_adr_wr,
  output logic              ev_cfg_wr,
  output logic              ev_cfg_rd,
  output logic              ev_sts_rd
);

  logic       cfg_we;
  logic [7:0] cfg_wadr;
  logic       fetch_en, fetch_bank;
  logic [7:0] fetch_adr;

  spi_rbank_ctrl #(.NCFG(NCFG), .NSTS(NSTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .rx_vld(rx_vld), .rx_data(rx_data),
    .ctl_q(ctl_reg), .adr_q(adr_reg),
    .cfg_we(cfg_we), .cfg_wadr(cfg_wadr),
    .fetch_en(fetch_en), .fetch_bank(fetch_bank), .fetch_adr(fetch_adr),
    .ev_ctl_wr(ev_ctl_wr), .ev_adr_wr(ev_adr_wr), .ev_cfg_wr(ev_cfg_wr),
    .ev_cfg_rd(ev_cfg_rd), .ev_sts_rd(ev_sts_rd)
  );

  spi_rbank_cfg #(.NCFG(NCFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wadr(cfg_wadr),
    .wdata(rx_data), .flat(cfg_flat)
  );

  spi_rbank_rd #(.NCFG(NCFG), .NSTS(NSTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_bank(fetch_bank),
    .fetch_adr(fetch_adr), .cfg_flat(cfg_flat), .sts_flat(sts_flat),
    .tx_q(tx_data)
  );

  assign usr_flags = ctl_reg[7:3];

  // R11: never two strobes together
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ctl_wr, ev_adr_wr, ev_cfg_wr, ev_cfg_rd, ev_sts_rd}));

  // R7: a configuration write only happens with the configuration bank selected
  a_r7_cfg_bank_only: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !ctl_reg[CB_BANK]);

endmodule

// File: tb/spi_rbank_top_bench.sv
module spi_rbank_top_bench;

  localparam int NCFG = 4;
  localparam int NSTS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_act = 1'b0;
  logic              rx_vld = 1'b0;
  logic [7:0]        rx_data = 8'h00;
  logic [7:0]        tx_data;
  logic [NSTS*8-1:0] sts_flat = 32'hC3330FA5;
  logic [NCFG*8-1:0] cfg_flat;
  logic [7:0]        ctl_reg, adr_reg;
  logic [4:0]        usr_flags;
  logic              ev_ctl_wr, ev_adr_wr, ev_cfg_wr, ev_cfg_rd, ev_sts_rd;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [NCFG];
  logic [4:0] ev_cap;

  always #2 clk = ~clk;

  spi_rbank_top #(.NCFG(NCFG), .NSTS(NSTS)) u_spi_rbank_top (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .rx_vld(rx_vld),
    .rx_data(rx_data), .tx_data(tx_data), .sts_flat(sts_flat),
    .cfg_flat(cfg_flat), .ctl_reg(ctl_reg), .adr_reg(adr_reg),
    .usr_flags(usr_flags), .ev_ctl_wr(ev_ctl_wr), .ev_adr_wr(ev_adr_wr),
    .ev_cfg_wr(ev_cfg_wr), .ev_cfg_rd(ev_cfg_rd), .ev_sts_rd(ev_sts_rd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_flat();
    logic [31:0] v;
    for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  // Strobe vector order: {ctl, adr, cfg_wr, cfg_rd, sts_rd}
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_vld  = 1'b1;
    @(negedge clk);
    rx_vld  = 1'b0;
    ev_cap  = {ev_ctl_wr, ev_adr_wr, ev_cfg_wr, ev_cfg_rd, ev_sts_rd};
  endtask

  task automatic frame_on();
    @(negedge clk);
    frame_act = 1'b1;
  endtask

  task automatic frame_off();
    @(negedge clk);
    frame_act = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_reg, 0);
    chk("R1 adr", adr_reg, 0);
    chk("R1 cfg", cfg_flat, 0);
    chk("R1 tx", tx_data, 0);
    chk("R1 strobes", {ev_ctl_wr, ev_adr_wr, ev_cfg_wr, ev_cfg_rd, ev_sts_rd}, 0);
  endtask

  task automatic t_write_wrap();
    frame_on();
    send(8'hF8);
    chk("R2 ctl stored", ctl_reg, 8'hF8);
    chk("R2 ctl strobe", ev_cap, 5'b10000);
    chk("R3 user flags", usr_flags, 5'h1F);
    @(negedge clk);
    chk("R11 strobe one cycle", {ev_ctl_wr, ev_adr_wr, ev_cfg_wr, ev_cfg_rd, ev_sts_rd}, 0);
    send(8'h02);
    chk("R2 adr stored", adr_reg, 8'h02);
    chk("R2 adr strobe", ev_cap, 5'b01000);
    send(8'h55); mdl[2] = 8'h55;
    chk("R4 cfg strobe", ev_cap, 5'b00100);
    chk("R5 step", adr_reg, 8'h03);
    send(8'hAA); mdl[3] = 8'hAA;
    chk("R5 wrap to 0", adr_reg, 8'h00);
    send(8'h3C); mdl[0] = 8'h3C;
    chk("R4 flat image", cfg_flat, mdl_flat());
    frame_off();
  endtask

  task automatic t_hold();
    frame_on();
    send(8'h04);
    send(8'h01);
    send(8'h11);
    send(8'h22); mdl[1] = 8'h22;
    chk("R6 pointer held", adr_reg, 8'h01);
    chk("R6 image", cfg_flat, mdl_flat());
    frame_off();
  endtask

  task automatic t_cfg_read();
    frame_on();
    send(8'h01);
    send(8'h03);
    chk("R8 preload at addr", tx_data, mdl[3]);
    send(8'h00);
    chk("R8 cfg read strobe", ev_cap, 5'b00010);
    chk("R8 next byte after wrap", tx_data, mdl[0]);
    chk("R8 read leaves bank", cfg_flat, mdl_flat());
    frame_off();
  endtask

  task automatic t_sts_read();
    frame_on();
    send(8'h03);
    send(8'h01);
    chk("R8 status preload", tx_data, 8'h0F);
    send(8'h00);
    chk("R8 status strobe", ev_cap, 5'b00001);
    chk("R8 status next", tx_data, 8'h33);
    frame_off();
  endtask

  task automatic t_sts_write();
    frame_on();
    send(8'h02);
    send(8'h00);
    send(8'hFF);
    chk("R7 no strobe", ev_cap, 5'b00000);
    chk("R7 cfg untouched", cfg_flat, mdl_flat());
    chk("R7 pointer steps", adr_reg, 8'h01);
    frame_off();
  endtask

  task automatic t_alias();
    frame_on();
    send(8'h01);
    send(8'h06);
    chk("R10 alias read", tx_data, mdl[2]);
    send(8'h00);
    chk("R10 alias step", adr_reg, 8'h03);
    frame_off();
  endtask

  task automatic t_outside();
    send(8'h77);
    chk("R9 no strobe outside", ev_cap, 5'b00000);
    chk("R9 ctl unchanged", ctl_reg, 8'h01);
    frame_on();
    send(8'h58);
    frame_off();
    frame_on();
    send(8'h09);
    chk("R9 restart with control", ctl_reg, 8'h09);
    chk("R9 restart strobe", ev_cap, 5'b10000);
    frame_off();
  endtask

  initial begin
    for (int i = 0; i < NCFG; i++) mdl[i] = 8'h00;
    ev_cap = 5'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_wrap();
    t_hold();
    t_cfg_read();
    t_sts_read();
    t_sts_write();
    t_alias();
    t_outside();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule